// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block gathers interrupt events from three core sources and from up to fourteen peripheral sources and turns them into one interrupt request line for the CPU. The core sources are a timer overflow pulse, an external pin with a selectable active edge, and an 8-pin input port that raises an event when any individually enabled pin changes. Each peripheral event arrives as a one-cycle pulse on its own input line.

Every source has a sticky flag bit and an enable bit. A flag records its event whatever the state of its enable. The request is gated at two levels. A global enable gates everything. A peripheral-group enable gates only the peripheral sources. Software reads and writes the registers through a simple single-cycle register bus. It clears flags by writing ones to them. Two peripheral flags also clear as a side effect: the receive-ready flag clears on a read of the receive data register, and the transmit-empty flag clears on a write to the transmit data register.

The register map has eight word addresses:

| Address | Register | Behaviour |
|---|---|---|
| 0 | Control | Read/write |
| 1 | Core flags | Read, write-one-to-clear |
| 2 | Port pin enables | Read/write |
| 3 | Port value | Read returns the pins and takes the snapshot |
| 4 | Peripheral enables | Read/write |
| 5 | Peripheral flags | Read, write-one-to-clear |
| 6 | Receive data | Read clears the receive-ready flag and returns 0 |
| 7 | Transmit data | Write clears the transmit-empty flag |

In the Control register, bit 0 enables the timer source, bit 1 the external pin source and bit 2 the port-change source. Bit 3 selects the external edge: 1 for rising, 0 for falling. Bit 6 is the peripheral-group enable and bit 7 the global enable. In the core flags register, bit 0 is the timer flag, bit 1 the external pin flag and bit 2 the port-change flag.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every enable, every flag, the port snapshot and the control register read as 0, and `irq` is 0.
- R2: A source event sets its flag on the next clock edge even when that source's enable bit is 0. This applies to `timerTick`, the external edge, port change and `periphEvt[i]`.
- R3: A set flag stays set until software clears it, and `irq` stays high for as long as an enabled flag stays set.
- R4: When Control bit 7 (global enable) is 0, `irq` is 0 whatever the flags and the other enables hold.
- R5: Control bit 6 (peripheral-group enable) masks only the peripheral flags. An enabled timer, external or port-change flag drives `irq` high while bit 6 is 0.
- R6: With Control bit 3 = 1 a 0→1 change of `extPin` sets core flag bit 1; with bit 3 = 0 a 1→0 change sets it; the opposite change does not.
- R7: Core flag bit 2 sets when any pin whose bit in the port pin enables register (address 2) is 1 differs from the port snapshot, in either direction. Pins whose enable bit is 0 are ignored.
- R8: A read of address 3 returns `portIn` and loads the snapshot with `portIn`. Until such a read, a changed enabled pin keeps setting core flag bit 2 again after each clear.
- R9: A read of address 6 clears peripheral flag `RX_IDX` (default 1) and returns 0. A write to address 7 clears peripheral flag `TX_IDX` (default 2).
- R10: Writing a 1 to a bit of address 1 or address 5 clears that flag. If a clear and a new event of the same flag land in the same cycle, the flag stays set.
- R11: `irq` = global enable AND (any core flag with its enable set OR (group enable AND any peripheral flag with its bit set in address 4)).
- R12: Each of addresses 0, 1, 2, 4 and 5 reads back the value it holds, zero-extended to the bus width. Only one register side effect is decoded per bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register word address |
| busWdata | input | DATA_W (16) | Write data |
| busRdata | output | DATA_W (16) | Read data, combinational from the address |
| timerTick | input | 1 | One-cycle timer overflow pulse |
| extPin | input | 1 | External interrupt pin, synchronous to clk |
| portIn | input | PORT_W (8) | Port pins watched for change, synchronous to clk |
| periphEvt | input | NUM_PERIPH (14) | One-cycle peripheral event pulses |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
An event pulse or pin change driven during a cycle sets its flag at the next rising edge. Because `irq` is combinational from the registers, `irq` moves in that same cycle. A bus write or side-effecting read takes effect at the edge that ends its bus cycle, and read data is valid during the bus cycle itself. The bench drives inputs just after each rising edge and samples `irq` and `busRdata` on the falling edge. It compares both every cycle against a behavioural model that is stepped on the rising edge. Directed reads then confirm each flag state one cycle after its stimulus, including the same-cycle clear-and-event collision and the clear attempt made before the port snapshot is re-armed.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic [2:0] {
    REG_CTL   = 3'd0,
    REG_CFLAG = 3'd1,
    REG_PMASK = 3'd2,
    REG_PORT  = 3'd3,
    REG_PEN   = 3'd4,
    REG_PFLAG = 3'd5,
    REG_RX    = 3'd6,
    REG_TX    = 3'd7
  } regSel_e;

  // Control register bit positions
  localparam int CTL_TIMER_EN  = 0;
  localparam int CTL_EXT_EN    = 1;
  localparam int CTL_PORT_EN   = 2;
  localparam int CTL_EXT_RISE  = 3;
  localparam int CTL_GROUP_EN  = 6;
  localparam int CTL_GLOBAL_EN = 7;
  localparam int CTL_W         = 8;

  // Core flag bit positions
  localparam int CF_TIMER = 0;
  localparam int CF_EXT   = 1;
  localparam int CF_PORT  = 2;
  localparam int CF_W     = 3;

  typedef struct packed {
    logic wrCtl;
    logic clrCore;
    logic wrPortMask;
    logic rdPort;
    logic wrPeriphEn;
    logic clrPeriph;
    logic rdRx;
    logic wrTx;
  } strobes_t;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [2:0] busAddr,
  output strobes_t   stb
);

  logic isRead;
  logic isWrite;

  assign isRead  = busSel & ~busWr;
  assign isWrite = busSel & busWr;

  always_comb begin
    stb            = '0;
    stb.wrCtl      = isWrite && (busAddr == REG_CTL);
    stb.clrCore    = isWrite && (busAddr == REG_CFLAG);
    stb.wrPortMask = isWrite && (busAddr == REG_PMASK);
    stb.rdPort     = isRead  && (busAddr == REG_PORT);
    stb.wrPeriphEn = isWrite && (busAddr == REG_PEN);
    stb.clrPeriph  = isWrite && (busAddr == REG_PFLAG);
    stb.rdRx       = isRead  && (busAddr == REG_RX);
    stb.wrTx       = isWrite && (busAddr == REG_TX);
  end

  // R12: one side effect per bus cycle
  a_r12_single_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb))
    else $error("a_r12_single_strobe");

  // R12: no strobe without a bus access
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busSel |-> (stb == '0))
    else $error("a_r12_idle_quiet");

endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int PORT_W     = 8,
  parameter int NUM_PERIPH = 14,
  parameter int RX_IDX     = 1,
  parameter int TX_IDX     = 2,
  parameter int DATA_W     = 16
)(
  input  logic                  clk,
  input  logic                  rst,
  input  strobes_t              stb,
  input  logic [2:0]            busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic                  timerTick,
  input  logic                  extPin,
  input  logic [PORT_W-1:0]     portIn,
  input  logic [NUM_PERIPH-1:0] periphEvt,
  output logic                  irq
);

  logic [CTL_W-1:0]      ctlReg;
  logic [CF_W-1:0]       coreFlag;
  logic [PORT_W-1:0]     portMask;
  logic [PORT_W-1:0]     portSnap;
  logic [NUM_PERIPH-1:0] periphEn;
  logic [NUM_PERIPH-1:0] periphFlag;
  logic                  extPrev;

  logic                  extRiseEv;
  logic                  extFallEv;
  logic                  extEv;
  logic [PORT_W-1:0]     pinChg;
  logic                  portEv;
  logic [CF_W-1:0]       coreEvt;
  logic [CF_W-1:0]       coreClr;
  logic [CF_W-1:0]       coreEnVec;
  logic [NUM_PERIPH-1:0] periphClr;
  logic                  coreHit;
  logic                  periphHit;

  // R6: edge detection on the external pin
  assign extRiseEv = extPin & ~extPrev;
  assign extFallEv = ~extPin & extPrev;
  assign extEv     = ctlReg[CTL_EXT_RISE] ? extRiseEv : extFallEv;

  // R7: per-pin comparison against the snapshot
  for (genvar p = 0; p < PORT_W; p++) begin : g_pin
    assign pinChg[p] = portMask[p] & (portIn[p] ^ portSnap[p]);
  end
  assign portEv = |pinChg;

  always_comb begin
    coreEvt           = '0;
    coreEvt[CF_TIMER] = timerTick;
    coreEvt[CF_EXT]   = extEv;
    coreEvt[CF_PORT]  = portEv;
  end

  assign coreClr = stb.clrCore ? busWdata[CF_W-1:0] : '0;

  // R9: side-effect clears for the two peripheral data registers
  always_comb begin
    periphClr = stb.clrPeriph ? busWdata[NUM_PERIPH-1:0] : '0;
    if (stb.rdRx) periphClr[RX_IDX] = 1'b1;
    if (stb.wrTx) periphClr[TX_IDX] = 1'b1;
  end

  if (NUM_PERIPH < DATA_W) begin : g_spare
    logic unusedHigh;
    assign unusedHigh = ^busWdata[DATA_W-1:NUM_PERIPH];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ctlReg     <= '0;
      coreFlag   <= '0;
      portMask   <= '0;
      portSnap   <= '0;
      periphEn   <= '0;
      periphFlag <= '0;
      extPrev    <= 1'b0;
    end else begin
      extPrev    <= extPin;
      // R10: set after clear, so an event wins a collision
      coreFlag   <= (coreFlag & ~coreClr) | coreEvt;
      periphFlag <= (periphFlag & ~periphClr) | periphEvt;
      if (stb.wrCtl)      ctlReg   <= busWdata[CTL_W-1:0];
      if (stb.wrPortMask) portMask <= busWdata[PORT_W-1:0];
      if (stb.wrPeriphEn) periphEn <= busWdata[NUM_PERIPH-1:0];
      if (stb.rdPort)     portSnap <= portIn;
    end
  end

  // R11: two-level gating of the request
  always_comb begin
    coreEnVec           = '0;
    coreEnVec[CF_TIMER] = ctlReg[CTL_TIMER_EN];
    coreEnVec[CF_EXT]   = ctlReg[CTL_EXT_EN];
    coreEnVec[CF_PORT]  = ctlReg[CTL_PORT_EN];
  end
  assign coreHit   = |(coreFlag & coreEnVec);
  assign periphHit = |(periphFlag & periphEn);
  assign irq       = ctlReg[CTL_GLOBAL_EN] &
                     (coreHit | (ctlReg[CTL_GROUP_EN] & periphHit));

  // R12: read-back multiplexer
  always_comb begin
    busRdata = '0;
    case (busAddr)
      REG_CTL:   busRdata[CTL_W-1:0]      = ctlReg;
      REG_CFLAG: busRdata[CF_W-1:0]       = coreFlag;
      REG_PMASK: busRdata[PORT_W-1:0]     = portMask;
      REG_PORT:  busRdata[PORT_W-1:0]     = portIn;
      REG_PEN:   busRdata[NUM_PERIPH-1:0] = periphEn;
      REG_PFLAG: busRdata[NUM_PERIPH-1:0] = periphFlag;
      default:   busRdata = '0;
    endcase
  end

  // R2: timer flag latches regardless of enable
  a_r2_timer_latch: assert property (@(posedge clk) disable iff (rst)
    timerTick |=> coreFlag[CF_TIMER])
    else $error("a_r2_timer_latch");

  // R3: a flag is only lost through a software clear
  a_r3_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (coreFlag[CF_TIMER] && !(stb.clrCore && busWdata[CF_TIMER])) |=> coreFlag[CF_TIMER])
    else $error("a_r3_flag_holds");

  // R6: rising edge with rising select sets the external flag
  a_r6_rise_sets: assert property (@(posedge clk) disable iff (rst)
    (ctlReg[CTL_EXT_RISE] && extPin && !extPrev) |=> coreFlag[CF_EXT])
    else $error("a_r6_rise_sets");

  // R8: a port read re-arms the detector with the pins seen
  a_r8_rearm: assert property (@(posedge clk) disable iff (rst)
    stb.rdPort |=> (portSnap == $past(portIn)))
    else $error("a_r8_rearm");

  // R9: receive read clears its flag unless a new event arrives
  a_r9_rx_clear: assert property (@(posedge clk) disable iff (rst)
    (stb.rdRx && !periphEvt[RX_IDX]) |=> !periphFlag[RX_IDX])
    else $error("a_r9_rx_clear");

  // R9: transmit write clears its flag unless a new event arrives
  a_r9_tx_clear: assert property (@(posedge clk) disable iff (rst)
    (stb.wrTx && !periphEvt[TX_IDX]) |=> !periphFlag[TX_IDX])
    else $error("a_r9_tx_clear");

  // R10: an event always leaves its flag set
  for (genvar k = 0; k < NUM_PERIPH; k++) begin : g_evchk
    a_r10_event_wins: assert property (@(posedge clk) disable iff (rst)
      periphEvt[k] |=> periphFlag[k])
      else $error("a_r10_event_wins");
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int PORT_W     = 8,
  parameter int NUM_PERIPH = 14,
  parameter int RX_IDX     = 1,
  parameter int TX_IDX     = 2,
  parameter int DATA_W     = 16
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic [2:0]            busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic                  timerTick,
  input  logic                  extPin,
  input  logic [PORT_W-1:0]     portIn,
  input  logic [NUM_PERIPH-1:0] periphEvt,
  output logic                  irq
);

  strobes_t stb;

  irq_agg_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .stb     (stb)
  );

  irq_agg_dp #(
    .PORT_W     (PORT_W),
    .NUM_PERIPH (NUM_PERIPH),
    .RX_IDX     (RX_IDX),
    .TX_IDX     (TX_IDX),
    .DATA_W     (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .timerTick (timerTick),
    .extPin    (extPin),
    .portIn    (portIn),
    .periphEvt (periphEvt),
    .irq       (irq)
  );

endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;

  localparam int CLK_PERIOD = 10;
  localparam int PW  = 8;
  localparam int NP  = 14;
  localparam int DW  = 16;
  localparam int RXI = 1;
  localparam int TXI = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          busSel = 1'b0;
  logic          busWr = 1'b0;
  logic [2:0]    busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic          timerTick = 1'b0;
  logic          extPin = 1'b0;
  logic [PW-1:0] portIn = '0;
  logic [NP-1:0] periphEvt = '0;
  logic          irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator #(.PORT_W(PW), .NUM_PERIPH(NP), .RX_IDX(RXI), .TX_IDX(TXI), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .timerTick(timerTick), .extPin(extPin),
    .portIn(portIn), .periphEvt(periphEvt), .irq(irq)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mCtl, mCf, mMask, mSnap, mPen, mPf, mExtPrev;

  function automatic int modelRd(int a);
    case (a)
      0: return mCtl;
      1: return mCf;
      2: return mMask;
      3: return int'(portIn);
      4: return mPen;
      5: return mPf;
      default: return 0;
    endcase
  endfunction

  function automatic int modelIrq();
    int coreEn;
    coreEn = mCtl & 7;
    if ((mCtl & 128) == 0) return 0;
    if ((mCf & coreEn) != 0) return 1;
    if (((mCtl & 64) != 0) && ((mPf & mPen) != 0)) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mCtl = 0; mCf = 0; mMask = 0; mSnap = 0; mPen = 0; mPf = 0; mExtPrev = 0;
    end else begin
      int ev;
      int pin;
      int clrC;
      int clrP;
      int a;
      pin = int'(extPin);
      a = int'(busAddr);
      ev = 0;
      if (timerTick) ev += 1;
      if (((mCtl & 8) != 0) ? (pin == 1 && mExtPrev == 0) : (pin == 0 && mExtPrev == 1)) ev += 2;
      if (((int'(portIn) ^ mSnap) & mMask) != 0) ev += 4;
      clrC = (busSel && busWr && a == 1) ? (int'(busWdata) & 7) : 0;
      clrP = (busSel && busWr && a == 5) ? (int'(busWdata) & ((1 << NP) - 1)) : 0;
      if (busSel && !busWr && a == 6) clrP |= (1 << RXI);
      if (busSel && busWr && a == 7) clrP |= (1 << TXI);
      mCf = (mCf & ~clrC) | ev;
      mPf = (mPf & ~clrP) | int'(periphEvt);
      mExtPrev = pin;
      if (busSel && busWr && a == 0) mCtl = int'(busWdata) & 255;
      if (busSel && busWr && a == 2) mMask = int'(busWdata) & ((1 << PW) - 1);
      if (busSel && busWr && a == 4) mPen = int'(busWdata) & ((1 << NP) - 1);
      if (busSel && !busWr && a == 3) mSnap = int'(portIn);
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R11 irq vs model", int'(irq), modelIrq());
      if (busSel && !busWr) chk("R12 read vs model", int'(busRdata), modelRd(int'(busAddr)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(int a, int d);
    busSel = 1'b1; busWr = 1'b1; busAddr = 3'(a); busWdata = DW'(d);
    cyc();
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    busSel = 1'b1; busWr = 1'b0; busAddr = 3'(a);
    @(negedge clk);
    chk(tag, int'(busRdata), exp);
    cyc();
    busSel = 1'b0;
  endtask

  task automatic irqIs(int exp, string tag);
    @(negedge clk);
    chk(tag, int'(irq), exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    rd(0, 0, "R1 control");
    rd(1, 0, "R1 core flags");
    rd(2, 0, "R1 port enables");
    rd(4, 0, "R1 periph enables");
    rd(5, 0, "R1 periph flags");
    irqIs(0, "R1 irq");

    // R2 latch with enable off
    timerTick = 1'b1; cyc(); timerTick = 1'b0;
    rd(1, 1, "R2 timer flag latched while disabled");
    irqIs(0, "R2 no irq while disabled");

    // R3 persistence, R4 global gate, R11 request
    cyc(); cyc(); cyc();
    rd(1, 1, "R3 flag persists");
    wr(0, 'h01);
    irqIs(0, "R4 global off");
    wr(0, 'h81);
    irqIs(1, "R11 timer request");
    cyc(); cyc();
    irqIs(1, "R3 request persists");

    // R10 clear and collision
    wr(1, 1);
    rd(1, 0, "R10 write-one clear");
    irqIs(0, "R10 irq after clear");
    timerTick = 1'b1; wr(1, 1); timerTick = 1'b0;
    rd(1, 1, "R10 event wins collision");
    wr(1, 1);

    // R6 edge select
    wr(0, 'h82);
    extPin = 1'b1; cyc();
    rd(1, 0, "R6 rising ignored in falling mode");
    extPin = 1'b0; cyc();
    rd(1, 2, "R6 falling sets");
    irqIs(1, "R6 ext request");
    wr(1, 2);
    wr(0, 'h8A);
    extPin = 1'b1; cyc();
    rd(1, 2, "R6 rising sets");
    wr(1, 2);
    extPin = 1'b0; cyc();
    rd(1, 0, "R6 falling ignored in rising mode");

    // R7 / R8 port change
    wr(2, 'h0F);
    rd(3, 0, "R8 port read");
    portIn = 8'h30; cyc();
    rd(1, 0, "R7 disabled pins ignored");
    portIn = 8'h31; cyc();
    rd(1, 4, "R7 enabled pin rise");
    wr(0, 'h84);
    irqIs(1, "R7 port request");
    wr(1, 4);
    rd(1, 4, "R8 clear before re-arm refires");
    rd(3, 'h31, "R8 port value");
    wr(1, 4);
    rd(1, 0, "R8 cleared after re-arm");
    portIn = 8'h30; cyc();
    rd(1, 4, "R7 enabled pin fall");
    rd(3, 'h30, "R8 port value 2");
    wr(1, 4);
    rd(1, 0, "R8 cleared 2");

    // R5 group gate
    wr(0, 'h80);
    wr(4, 'h0020);
    periphEvt = 14'h0020; cyc(); periphEvt = '0;
    rd(5, 'h20, "R2 periph flag latched");
    irqIs(0, "R5 group disabled masks periph");
    wr(0, 'hC0);
    irqIs(1, "R5 group enabled passes periph");
    wr(5, 'h20);
    irqIs(0, "R10 periph clear drops irq");
    wr(0, 'h81);
    timerTick = 1'b1; cyc(); timerTick = 1'b0;
    irqIs(1, "R5 core source not gated by group");
    wr(1, 1);

    // R9 data-register side effects
    periphEvt = 14'h0006; cyc(); periphEvt = '0;
    rd(5, 6, "R9 rx and tx flags set");
    rd(6, 0, "R9 rx read returns zero");
    rd(5, 4, "R9 rx read clears rx flag");
    wr(7, 'h55);
    rd(5, 0, "R9 tx write clears tx flag");

    // R10 periph collision
    periphEvt = 14'h0008; wr(5, 8); periphEvt = '0;
    rd(5, 8, "R10 periph event wins collision");
    wr(5, 8);
    rd(5, 0, "R10 periph cleared");

    // R4 global off with pending enabled periph flag
    wr(4, 8);
    periphEvt = 14'h0008; cyc(); periphEvt = '0;
    wr(0, 'h40);
    irqIs(0, "R4 global off blocks pending");
    rd(0, 'h40, "R12 control readback");
    rd(4, 8, "R12 periph enable readback");
    rd(2, 'h0F, "R12 port enable readback");

    cyc();
    summary();
    $finish;
  end

endmodule